// File: doc/BRIEF.md
# Multi-Mode Address Generation Unit

This unit sits between the decode stage and the data-memory stage of a load/store pipeline. Each request it accepts carries an addressing-mode code, a base and an index register value, a 16-bit immediate, a scale shift, the program counter, the access size and the identifier of the base register. From these it forms one effective address. The base and index values and the immediate may also be combined with a scaled index or with the program counter.

Two modes also update their base register. For these, the unit returns the new base value, the register identifier and a one-cycle write strobe when the result is handed on. One mode is memory-indirect. For that mode the unit first issues a read at the base value through its memory request port. It then waits for the response and hands on the returned word as the final address. Every result carries a flag that reports whether the address is misaligned for the requested access size.

Top module: `agu_top`

## Requirements
- R1: Mode code 0 (register-indirect) yields the base value as the address. Mode code 8 (absolute) yields the sign-extended immediate alone.
- R2: Mode code 1 (displacement) yields base plus the 16-bit immediate sign-extended to the address width.
- R3: Mode code 2 (index-base) yields base plus index.
- R4: Mode code 5 (scaled) yields base + (index << scale) + sign-extended immediate. The 2-bit scale field gives the shift 0 to 3, so the multiplier is 1, 2, 4 or 8.
- R5: Mode code 6 (PC-relative) yields the PC plus the sign-extended immediate.
- R6: Mode code 3 (auto-increment) yields the base as the address and base+1 as the write-back value.
- R7: Mode code 4 (auto-indexing) yields base plus the sign-extended immediate as the address, and the same sum as the write-back value.
- R8: `wb_en` is high for exactly one cycle per request, in the handoff cycle (`out_valid` and `out_ready` both high), and only for mode codes 3 and 4. `wb_reg` then equals the identifier given with the request.
- R9: Mode code 7 (memory-indirect) raises `mem_req_valid` with `mem_req_addr` equal to the base. The request stays stable until `mem_req_ready` is seen. `out_valid` stays low until `mem_rsp_valid`, and the final address is then `mem_rsp_data`.
- R10: The size code s means an access of 2^s bytes. `out_misalign` is high while `out_valid` is high and any of the low s bits of `out_addr` is set. It is low otherwise.
- R11: A request is accepted only while `req_ready` is high, and `req_ready` is low while a request is in flight. A non-indirect result appears with `out_valid` one cycle after acceptance. It is held unchanged until `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_mode | input | 4 | Addressing-mode code |
| req_base | input | 32 | Base register value |
| req_index | input | 32 | Index register value |
| req_imm | input | 16 | Immediate, signed |
| req_scale | input | 2 | Index shift amount |
| req_pc | input | 32 | Program counter |
| req_size | input | 2 | Access size code, 2^s bytes |
| req_breg | input | 5 | Base register identifier |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 32 | Effective address |
| out_misalign | output | 1 | Address misaligned for the size |
| wb_en | output | 1 | Base write-back strobe |
| wb_reg | output | 5 | Base register to write |
| wb_data | output | 32 | New base value |
| mem_req_valid | output | 1 | Indirect read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Indirect read address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Read data |

## Verification
The bench uses negative immediates in the displacement, scaled and PC-relative modes. A design that zero-extends the immediate would produce addresses about 64 KiB too high. Every scale shift from 0 to 3 is tried against the same index, so an off-by-one in the shift selection gives a wrong multiple. The bench checks write-back at handoff for both write-back modes and for modes that must not write, which catches a strobe that fires in the wrong mode or stays high.

For memory-indirect, the bench stalls both the request acceptance and the response. A design that skips the wait would hand on the base rather than the read data. A design that lets the request drift would read the wrong word. The alignment flag is driven with one address at several sizes, including a returned indirect word, so a mask built off by one bit is exposed.

// File: rtl/agu_pkg.sv
// Shared types for the address generation unit.
// Assumes mode codes are fixed by the pipeline decoder.
package agu_pkg;

    typedef enum logic [3:0] {
        AM_REG    = 4'd0,
        AM_DISP   = 4'd1,
        AM_IDXB   = 4'd2,
        AM_AINC   = 4'd3,
        AM_AIDX   = 4'd4,
        AM_SCALED = 4'd5,
        AM_PCREL  = 4'd6,
        AM_MIND   = 4'd7,
        AM_ABS    = 4'd8
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MREQ  = 2'd1,
        ST_MWAIT = 2'd2,
        ST_DONE  = 2'd3
    } ast_e;

endpackage

// File: rtl/agu_addr_calc.sv
// Combinational address former: sign-extends the immediate, scales the
// index by a left shift and selects the sum for the requested mode.
// Assumes AW >= IMM_W. Unknown mode codes fall back to the base value.
module agu_addr_calc
    import agu_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IMM_W = 16,
    parameter int SH_W  = 2
) (
    input  logic [3:0]       mode,
    input  logic [AW-1:0]    base,
    input  logic [AW-1:0]    index,
    input  logic [IMM_W-1:0] imm,
    input  logic [SH_W-1:0]  shamt,
    input  logic [AW-1:0]    pc,
    output logic [AW-1:0]    addr,
    output logic [AW-1:0]    wb_value,
    output logic             wb_mode,
    output logic             indirect
);
    localparam int NSH = 1 << SH_W;

    logic [AW-1:0] simm;
    logic [AW-1:0] shifted [NSH];
    logic [AW-1:0] scaled_idx;
    logic [AW-1:0] base_plus_imm;
    amode_e        m;

    // sign extension of the immediate to the address width
    generate
        if (AW > IMM_W) begin : g_sext
            assign simm = {{(AW-IMM_W){imm[IMM_W-1]}}, imm};
        end else begin : g_nosext
            assign simm = imm[AW-1:0];
        end
    endgenerate

    // one shifted copy of the index per legal scale
    generate
        for (genvar g = 0; g < NSH; g++) begin : g_shift
            assign shifted[g] = index << g;
        end
    endgenerate

    assign scaled_idx    = shifted[shamt];
    assign base_plus_imm = base + simm;
    assign m             = amode_e'(mode);

    // mode selection of address and write-back value
    always_comb begin
        addr     = base;
        wb_value = base_plus_imm;
        wb_mode  = 1'b0;
        indirect = 1'b0;
        case (m)
            AM_REG:    addr = base;
            AM_DISP:   addr = base_plus_imm;
            AM_IDXB:   addr = base + index;
            AM_AINC: begin
                addr     = base;
                wb_value = base + {{(AW-1){1'b0}}, 1'b1};
                wb_mode  = 1'b1;
            end
            AM_AIDX: begin
                addr     = base_plus_imm;
                wb_value = base_plus_imm;
                wb_mode  = 1'b1;
            end
            AM_SCALED: addr = base + scaled_idx + simm;
            AM_PCREL:  addr = pc + simm;
            AM_MIND: begin
                addr     = base;
                indirect = 1'b1;
            end
            AM_ABS:    addr = simm;
            default:   addr = base;
        endcase
    end

endmodule

// File: rtl/agu_align.sv
// Misalignment detector: flags an address whose low bits are not zero
// for an access of 2^size bytes. Assumes size codes up to 2^SZ_W - 1.
module agu_align #(
    parameter int SZ_W = 2
) (
    input  logic [(1<<SZ_W)-2:0] addr_lo,
    input  logic [SZ_W-1:0]      size,
    output logic                 misalign
);
    localparam int LW = (1 << SZ_W) - 1;

    logic [LW-1:0] mask;

    // mask of the low bits that must be zero for this size
    always_comb begin
        for (int i = 0; i < LW; i++) begin
            mask[i] = (i < int'(size));
        end
    end

    assign misalign = |(addr_lo & mask);

endmodule

// File: rtl/agu_ctrl.sv
// Sequencer for request acceptance, the optional indirect memory read
// and the result handoff. Assumes one request in flight at a time.
module agu_ctrl
    import agu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic is_indirect,
    input  logic mem_req_ready,
    input  logic mem_rsp_valid,
    input  logic out_ready,
    output logic req_ready,
    output logic accept,
    output logic mem_req_valid,
    output logic load_rsp,
    output logic out_valid,
    output logic handoff
);
    ast_e state, state_nx;

    // state register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign req_ready     = (state == ST_IDLE);
    assign accept        = req_ready & req_valid;
    assign mem_req_valid = (state == ST_MREQ);
    assign load_rsp      = (state == ST_MWAIT) & mem_rsp_valid;
    assign out_valid     = (state == ST_DONE);
    assign handoff       = out_valid & out_ready;

    // next-state selection
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:  if (accept) state_nx = is_indirect ? ST_MREQ : ST_DONE;
            ST_MREQ:  if (mem_req_ready) state_nx = ST_MWAIT;
            ST_MWAIT: if (mem_rsp_valid) state_nx = ST_DONE;
            ST_DONE:  if (out_ready) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/agu_top.sv
// Address generation unit top: forms an effective address per request,
// performs the indirect read when asked and returns base write-back.
// Assumes the consumer and memory follow valid/ready rules.
module agu_top #(
    parameter int AW    = 32,
    parameter int IMM_W = 16,
    parameter int SH_W  = 2,
    parameter int SZ_W  = 2,
    parameter int RID_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [3:0]       req_mode,
    input  logic [AW-1:0]    req_base,
    input  logic [AW-1:0]    req_index,
    input  logic [IMM_W-1:0] req_imm,
    input  logic [SH_W-1:0]  req_scale,
    input  logic [AW-1:0]    req_pc,
    input  logic [SZ_W-1:0]  req_size,
    input  logic [RID_W-1:0] req_breg,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [AW-1:0]    out_addr,
    output logic             out_misalign,
    output logic             wb_en,
    output logic [RID_W-1:0] wb_reg,
    output logic [AW-1:0]    wb_data,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [AW-1:0]    mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [AW-1:0]    mem_rsp_data
);
    localparam int LW = (1 << SZ_W) - 1;

    logic [AW-1:0]    calc_addr, calc_wb;
    logic             calc_wb_mode, calc_ind;
    logic             accept, load_rsp, handoff, mis_raw;
    logic [AW-1:0]    r_addr, r_wb_data;
    logic [SZ_W-1:0]  r_size;
    logic             r_wb;
    logic [RID_W-1:0] r_breg;

    agu_addr_calc #(.AW(AW), .IMM_W(IMM_W), .SH_W(SH_W)) u_calc (
        .mode     (req_mode),
        .base     (req_base),
        .index    (req_index),
        .imm      (req_imm),
        .shamt    (req_scale),
        .pc       (req_pc),
        .addr     (calc_addr),
        .wb_value (calc_wb),
        .wb_mode  (calc_wb_mode),
        .indirect (calc_ind)
    );

    agu_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .is_indirect   (calc_ind),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .out_ready     (out_ready),
        .req_ready     (req_ready),
        .accept        (accept),
        .mem_req_valid (mem_req_valid),
        .load_rsp      (load_rsp),
        .out_valid     (out_valid),
        .handoff       (handoff)
    );

    agu_align #(.SZ_W(SZ_W)) u_align (
        .addr_lo  (r_addr[LW-1:0]),
        .size     (r_size),
        .misalign (mis_raw)
    );

    // result register: loaded on acceptance, replaced by indirect data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_addr    <= '0;
            r_wb_data <= '0;
            r_size    <= '0;
            r_wb      <= 1'b0;
            r_breg    <= '0;
        end else if (accept) begin
            r_addr    <= calc_addr;
            r_wb_data <= calc_wb;
            r_size    <= req_size;
            r_wb      <= calc_wb_mode;
            r_breg    <= req_breg;
        end else if (load_rsp) begin
            r_addr    <= mem_rsp_data;
        end
    end

    assign out_addr     = r_addr;
    assign mem_req_addr = r_addr;
    assign out_misalign = out_valid & mis_raw;
    assign wb_en        = handoff & r_wb;
    assign wb_reg       = r_breg;
    assign wb_data      = r_wb_data;

endmodule

// File: rtl/agu_chk.sv
// Protocol checker for agu_top, attached by bind. Watches handshakes,
// write-back strobe and the misalignment qualifier.
module agu_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [AW-1:0] out_addr,
    input logic          out_misalign,
    input logic          wb_en,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [AW-1:0] mem_req_addr
);
    p_busy_blocks_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !req_ready);

    p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

    p_mreq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_mreq_no_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !out_valid);

    p_wb_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> (!wb_en && !out_valid));

    p_mis_qual_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_misalign |-> out_valid);

endmodule

bind agu_top agu_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_addr      (out_addr),
    .out_misalign  (out_misalign),
    .wb_en         (wb_en),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/sim_agu_top.sv
`timescale 1ns/1ps
module sim_agu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_mode = '0;
    logic [31:0] req_base = '0, req_index = '0, req_pc = '0;
    logic [15:0] req_imm = '0;
    logic [1:0]  req_scale = '0, req_size = '0;
    logic [4:0]  req_breg = '0;
    logic        out_valid, out_ready = 1'b0;
    logic [31:0] out_addr;
    logic        out_misalign, wb_en;
    logic [4:0]  wb_reg;
    logic [31:0] wb_data;
    logic        mem_req_valid, mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    agu_top u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive one non-indirect request; check result, hold and write-back
    task automatic run_op(input string tag, input logic [3:0] mode,
                          input logic [31:0] base, input logic [31:0] index,
                          input logic [15:0] imm, input logic [1:0] sc,
                          input logic [31:0] pc, input logic [1:0] size,
                          input logic [4:0] id, input logic [31:0] exp_addr,
                          input logic exp_mis, input logic exp_wb,
                          input logic [31:0] exp_wbd);
        @(negedge clk);
        req_mode = mode; req_base = base; req_index = index; req_imm = imm;
        req_scale = sc; req_pc = pc; req_size = size; req_breg = id;
        req_valid = 1'b1; out_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_base = 32'hDEAD_BEEF; req_imm = 16'h7777;
        chk({tag, " valid"}, 32'(out_valid), 32'd1);
        chk({"R11 busy ready ", tag}, 32'(req_ready), 32'd0);
        chk({tag, " addr"}, out_addr, exp_addr);
        chk({"R10 misalign ", tag}, 32'(out_misalign), 32'(exp_mis));
        chk({"R8 no wb before handoff ", tag}, 32'(wb_en), 32'd0);
        @(negedge clk);
        chk({"R11 hold ", tag}, out_addr, exp_addr);
        out_ready = 1'b1;
        #1;
        chk({"R8 wb_en ", tag}, 32'(wb_en), 32'(exp_wb));
        if (exp_wb) begin
            chk({"R8 wb_reg ", tag}, 32'(wb_reg), 32'(id));
            chk({tag, " wb_data"}, wb_data, exp_wbd);
        end
        @(negedge clk);
        out_ready = 1'b0;
        chk({"R8 wb single ", tag}, 32'(wb_en), 32'd0);
        chk({"R11 idle ", tag}, 32'(req_ready), 32'd1);
    endtask

    // memory-indirect request with stalled request and delayed response
    task automatic run_ind(input logic [31:0] base, input logic [31:0] data,
                           input logic [1:0] size, input logic exp_mis);
        @(negedge clk);
        req_mode = 4'd7; req_base = base; req_size = size; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_base = 32'h0;
        chk("R9 mreq valid", 32'(mem_req_valid), 32'd1);
        chk("R9 mreq addr", mem_req_addr, base);
        chk("R9 no early result", 32'(out_valid), 32'd0);
        @(negedge clk);
        chk("R9 mreq held", 32'(mem_req_valid), 32'd1);
        chk("R9 mreq addr held", mem_req_addr, base);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk("R9 mreq dropped", 32'(mem_req_valid), 32'd0);
        @(negedge clk);
        chk("R9 waiting for data", 32'(out_valid), 32'd0);
        mem_rsp_valid = 1'b1; mem_rsp_data = data;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = 32'h0;
        chk("R9 result valid", 32'(out_valid), 32'd1);
        chk("R9 final addr", out_addr, data);
        chk("R10 indirect misalign", 32'(out_misalign), 32'(exp_mis));
        out_ready = 1'b1;
        #1;
        chk("R8 no wb indirect", 32'(wb_en), 32'd0);
        @(negedge clk);
        out_ready = 1'b0;
        chk("R11 idle after indirect", 32'(req_ready), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset ready", 32'(req_ready), 32'd1);
        chk("R11 reset out_valid", 32'(out_valid), 32'd0);
        chk("R9 reset mreq", 32'(mem_req_valid), 32'd0);
        chk("R8 reset wb_en", 32'(wb_en), 32'd0);

        run_op("R1 regind", 4'd0, 32'h1000_0040, 0, 16'h0, 0, 0, 2'd2, 1, 32'h1000_0040, 0, 0, 0);
        run_op("R1 absolute", 4'd8, 32'h1234_5678, 0, 16'h8004, 0, 0, 2'd2, 1, 32'hFFFF_8004, 0, 0, 0);
        run_op("R2 disp neg", 4'd1, 32'h2000, 0, 16'hFFF0, 0, 0, 2'd3, 2, 32'h1FF0, 0, 0, 0);
        run_op("R2 disp pos", 4'd1, 32'h2000, 0, 16'h0100, 0, 0, 2'd0, 2, 32'h2100, 0, 0, 0);
        run_op("R3 idxbase", 4'd2, 32'h100, 32'h23, 16'h0, 0, 0, 2'd0, 3, 32'h123, 0, 0, 0);
        run_op("R4 scale1", 4'd5, 32'h1000, 32'h3, 16'h4, 2'd0, 0, 2'd0, 4, 32'h1007, 0, 0, 0);
        run_op("R4 scale2", 4'd5, 32'h1000, 32'h3, 16'h4, 2'd1, 0, 2'd1, 4, 32'h100A, 0, 0, 0);
        run_op("R4 scale4", 4'd5, 32'h1000, 32'h3, 16'h4, 2'd2, 0, 2'd2, 4, 32'h1010, 0, 0, 0);
        run_op("R4 scale8", 4'd5, 32'h1000, 32'h3, 16'h4, 2'd3, 0, 2'd2, 4, 32'h101C, 0, 0, 0);
        run_op("R4 scale8 neg", 4'd5, 32'h1000, 32'h3, 16'hFFF8, 2'd3, 0, 2'd3, 4, 32'h1010, 0, 0, 0);
        run_op("R5 pcrel", 4'd6, 32'h9999, 0, 16'hFFFC, 0, 32'h400, 2'd2, 5, 32'h3FC, 0, 0, 0);
        run_op("R6 autoinc", 4'd3, 32'h500, 0, 16'h40, 0, 0, 2'd0, 7, 32'h500, 0, 1, 32'h501);
        run_op("R7 autoidx", 4'd4, 32'h600, 0, 16'h20, 0, 0, 2'd2, 9, 32'h620, 0, 1, 32'h620);
        run_op("R7 autoidx neg", 4'd4, 32'h600, 0, 16'hFFFE, 0, 0, 2'd1, 31, 32'h5FE, 0, 1, 32'h5FE);
        run_op("R10 word odd", 4'd0, 32'h1002, 0, 0, 0, 0, 2'd2, 0, 32'h1002, 1, 0, 0);
        run_op("R10 half ok", 4'd0, 32'h1002, 0, 0, 0, 0, 2'd1, 0, 32'h1002, 0, 0, 0);
        run_op("R10 dword", 4'd0, 32'h1004, 0, 0, 0, 0, 2'd3, 0, 32'h1004, 1, 0, 0);
        run_op("R10 byte", 4'd0, 32'h1007, 0, 0, 0, 0, 2'd0, 0, 32'h1007, 0, 0, 0);
        run_ind(32'h0000_8000, 32'h0003_0040, 2'd2, 1'b0);
        run_ind(32'h0000_8010, 32'h0000_3001, 2'd1, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule